// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the two low-power modes of a small 8-bit microcontroller core. The core writes a power-control register. One bit asks for an idle halt, where only the CPU clock stops. Another bit asks for a full power-down, where the oscillator enable is also withdrawn. While a mode is active, the block drives the bus-control strobes and the four 8-bit ports with a fixed pattern. That pattern depends on the mode and on whether program memory is on-chip or off-chip.

The block watches the reset pin, the two active-low external interrupt pins and a combined peripheral interrupt request. From these it decides when the core wakes. It reports whether the core restarts from the reset vector or enters an interrupt service routine, and which source caused the wake. Power-down is left only through reset or through a level-triggered external interrupt that is enabled both individually and globally. After such a wake, the oscillator runs for a programmable warm-up interval before the CPU clock is released.

Top module: `lpm_ctrl`

## Requirements
- R1: A write strobe in run mode updates the power-control register at the next edge. Bit 1 set enters power-down, giving register bits 2'b10. Bit 0 set alone enters idle, giving 2'b01. Bit 1 wins when both are set. Bits 7..2 are ignored, and a write with bits 1..0 clear leaves the core running.
- R2: The CPU clock enable is 1 only in run mode. The oscillator enable is 0 only in power-down.
- R3: In idle, ALE and PSEN are both 1. In power-down and during warm-up, both are 0. In run mode, the core's own strobes pass through.
- R4: Outside run mode, ports 1 and 3 drive their SFR bytes. Port 0 drives its SFR byte with output enable 1 when program memory is internal, and floats (output enable 0) when it is external. Port 2 drives the address high byte only in idle with external program memory, and its SFR byte otherwise. In run mode, the core's port 0 and port 2 bus values pass through.
- R5: In power-down, external interrupt k wakes the device only when all of the following hold: its enable is set, the global enable is set, its edge-mode bit is 0 (level mode), and its pin is low. Edge mode, a cleared enable, a cleared global enable or the peripheral request never wakes it.
- R6: The edge after a power-down wake raises the oscillator enable and clears the register. The CPU clock enable stays 0 for WARM_CYCLES further edges. The CPU clock enable then rises together with a single-cycle interrupt-entry pulse.
- R7: In idle, a wake comes from any of three sources, provided the global enable is set. An enabled level-mode interrupt wakes on a low pin. An enabled edge-mode interrupt wakes on a sampled high-to-low transition, so a pin that was already low before idle does not wake it. The peripheral request also wakes it. The next edge returns to run mode, clears the idle bit and pulses interrupt entry for one cycle.
- R8: The wake source code is 0 for interrupt 0, 1 for interrupt 1 and 2 for the peripheral request. When several sources are active together, interrupt 0 wins over interrupt 1, and interrupt 1 wins over the peripheral request.
- R9: A high reset pin, sampled at a clock edge, forces run mode with both enables at 1 and the register cleared. The restart output is 1 after each edge that sees reset high, and 0 after the first edge that sees it low.
- R10: Register writes are ignored while reset is high and while the core is not in run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_pin | input | 1 | External reset pin, active high, sampled synchronously |
| pcon_we | input | 1 | Power-control register write strobe |
| pcon_wdata | input | 8 | Power-control write data (bit 0 idle, bit 1 power-down) |
| ext_prog | input | 1 | 1 when program memory is external |
| int_n | input | 2 | External interrupt pins, active low |
| int_en | input | 2 | Per-interrupt enable bits |
| int_edge | input | 2 | Per-interrupt mode: 1 edge, 0 level |
| glob_en | input | 1 | Global interrupt enable |
| periph_irq | input | 1 | Combined enabled peripheral interrupt request |
| run_ale | input | 1 | Core ALE in run mode |
| run_psen | input | 1 | Core PSEN in run mode |
| run_p0_out | input | 8 | Core port 0 bus value in run mode |
| run_p0_oe | input | 1 | Core port 0 output enable in run mode |
| run_p2_out | input | 8 | Core port 2 bus value in run mode |
| p0_sfr | input | 8 | Port 0 SFR byte |
| p1_sfr | input | 8 | Port 1 SFR byte |
| p2_sfr | input | 8 | Port 2 SFR byte |
| p3_sfr | input | 8 | Port 3 SFR byte |
| addr_hi | input | 8 | Current program address high byte |
| pcon_bits | output | 2 | Power-control register {power-down, idle} |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| ale | output | 1 | ALE pin |
| psen | output | 1 | PSEN pin |
| p0_out | output | 8 | Port 0 pin value |
| p0_oe | output | 1 | Port 0 output enable |
| p1_out | output | 8 | Port 1 pin value |
| p2_out | output | 8 | Port 2 pin value |
| p3_out | output | 8 | Port 3 pin value |
| irq_take | output | 1 | One-cycle pulse: enter interrupt service routine |
| irq_src | output | 2 | Wake source code |
| restart | output | 1 | Core restarts from address 0000h |

## Verification
The assertions check on every cycle the properties that hold in any state. These are the clock and oscillator gating tied to the register bits, the strobe levels for each mode, the floating of port 0 with external memory, the single-cycle interrupt pulse, and the reset outcome. They also check that power-down holds whenever both interrupts are in edge mode or the global enable is clear. Only the bench scenarios can show the rest. That covers the full pin pattern for each mode and memory combination, which enable combination wakes which mode, and the exact length of the warm-up. It also covers the edge-versus-level distinction in idle, the priority among simultaneous sources, and the writes that must be ignored.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int N_XINT = 2;
    localparam int SRC_W  = 2;

    localparam logic [SRC_W-1:0] SRC_INT0   = 2'd0;
    localparam logic [SRC_W-1:0] SRC_INT1   = 2'd1;
    localparam logic [SRC_W-1:0] SRC_PERIPH = 2'd2;

    localparam int PCON_IDLE_BIT = 0;
    localparam int PCON_PD_BIT   = 1;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_PDOWN = 2'd2,
        ST_WARM  = 2'd3
    } lpm_state_e;

    typedef struct packed {
        lpm_state_e        st;
        logic [1:0]        pcon;
        logic [N_XINT-1:0] int_prev;
        logic              irq_take;
        logic [SRC_W-1:0]  irq_src;
        logic              restart;
    } lpm_regs_t;

endpackage

// File: rtl/lpm_wake.sv
module lpm_wake
    import lpm_pkg::*;
(
    input  logic [N_XINT-1:0] int_n,
    input  logic [N_XINT-1:0] int_prev,
    input  logic [N_XINT-1:0] int_en,
    input  logic [N_XINT-1:0] int_edge,
    input  logic              glob_en,
    input  logic              periph_irq,
    output logic              pd_wake,
    output logic              idle_wake,
    output logic [SRC_W-1:0]  pd_src,
    output logic [SRC_W-1:0]  idle_src
);

    logic [N_XINT-1:0] pd_hit;
    logic [N_XINT-1:0] idle_hit;
    logic              periph_hit;

    for (genvar k = 0; k < N_XINT; k++) begin : g_src
        logic level_act;
        logic fall_act;
        logic allowed;
        assign level_act   = !int_edge[k] && !int_n[k];
        assign fall_act    = int_edge[k] && int_prev[k] && !int_n[k];
        assign allowed     = glob_en && int_en[k];
        assign pd_hit[k]   = allowed && level_act;
        assign idle_hit[k] = allowed && (level_act || fall_act);
    end

    assign periph_hit = glob_en && periph_irq;
    assign pd_wake    = |pd_hit;
    assign idle_wake  = (|idle_hit) || periph_hit;

    always_comb begin
        if (pd_hit[0]) pd_src = SRC_INT0;
        else           pd_src = SRC_INT1;
    end

    always_comb begin
        if (idle_hit[0])      idle_src = SRC_INT0;
        else if (idle_hit[1]) idle_src = SRC_INT1;
        else                  idle_src = SRC_PERIPH;
    end

endmodule

// File: rtl/lpm_warm_timer.sv
module lpm_warm_timer #(
    parameter int WARM_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_pin,
    input  logic active,
    output logic last
);

    localparam int CNT_W = $clog2(WARM_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WARM_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (active && cnt_q != CNT_LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_pin) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign last = active && (cnt_q == CNT_LAST);

endmodule

// File: rtl/lpm_pinmux.sv
module lpm_pinmux
    import lpm_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  lpm_state_e        st,
    input  logic              ext_prog,
    input  logic              run_ale,
    input  logic              run_psen,
    input  logic [PORT_W-1:0] run_p0_out,
    input  logic              run_p0_oe,
    input  logic [PORT_W-1:0] run_p2_out,
    input  logic [PORT_W-1:0] p0_sfr,
    input  logic [PORT_W-1:0] p1_sfr,
    input  logic [PORT_W-1:0] p2_sfr,
    input  logic [PORT_W-1:0] p3_sfr,
    input  logic [PORT_W-1:0] addr_hi,
    output logic              ale,
    output logic              psen,
    output logic [PORT_W-1:0] p0_out,
    output logic              p0_oe,
    output logic [PORT_W-1:0] p1_out,
    output logic [PORT_W-1:0] p2_out,
    output logic [PORT_W-1:0] p3_out
);

    assign p1_out = p1_sfr;
    assign p3_out = p3_sfr;

    always_comb begin
        ale    = run_ale;
        psen   = run_psen;
        p0_out = run_p0_out;
        p0_oe  = run_p0_oe;
        p2_out = run_p2_out;
        unique case (st)
            ST_RUN: ;
            ST_IDLE: begin
                ale    = 1'b1;
                psen   = 1'b1;
                p0_out = p0_sfr;
                p0_oe  = !ext_prog;
                p2_out = ext_prog ? addr_hi : p2_sfr;
            end
            default: begin
                ale    = 1'b0;
                psen   = 1'b0;
                p0_out = p0_sfr;
                p0_oe  = !ext_prog;
                p2_out = p2_sfr;
            end
        endcase
    end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int PORT_W      = 8,
    parameter int WARM_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_pin,
    input  logic              pcon_we,
    input  logic [7:0]        pcon_wdata,
    input  logic              ext_prog,
    input  logic [1:0]        int_n,
    input  logic [1:0]        int_en,
    input  logic [1:0]        int_edge,
    input  logic              glob_en,
    input  logic              periph_irq,
    input  logic              run_ale,
    input  logic              run_psen,
    input  logic [PORT_W-1:0] run_p0_out,
    input  logic              run_p0_oe,
    input  logic [PORT_W-1:0] run_p2_out,
    input  logic [PORT_W-1:0] p0_sfr,
    input  logic [PORT_W-1:0] p1_sfr,
    input  logic [PORT_W-1:0] p2_sfr,
    input  logic [PORT_W-1:0] p3_sfr,
    input  logic [PORT_W-1:0] addr_hi,
    output logic [1:0]        pcon_bits,
    output logic              cpu_clk_en,
    output logic              osc_en,
    output logic              ale,
    output logic              psen,
    output logic [PORT_W-1:0] p0_out,
    output logic              p0_oe,
    output logic [PORT_W-1:0] p1_out,
    output logic [PORT_W-1:0] p2_out,
    output logic [PORT_W-1:0] p3_out,
    output logic              irq_take,
    output logic [1:0]        irq_src,
    output logic              restart
);

    lpm_regs_t r_d, r_q;

    logic             pd_wake, idle_wake, warm_last;
    logic [SRC_W-1:0] pd_src, idle_src;

    lpm_wake u_wake (
        .int_n      (int_n),
        .int_prev   (r_q.int_prev),
        .int_en     (int_en),
        .int_edge   (int_edge),
        .glob_en    (glob_en),
        .periph_irq (periph_irq),
        .pd_wake    (pd_wake),
        .idle_wake  (idle_wake),
        .pd_src     (pd_src),
        .idle_src   (idle_src)
    );

    lpm_warm_timer #(.WARM_CYCLES(WARM_CYCLES)) u_warm (
        .clk     (clk),
        .rst_pin (rst_pin),
        .active  (r_q.st == ST_WARM),
        .last    (warm_last)
    );

    lpm_pinmux #(.PORT_W(PORT_W)) u_pins (
        .st         (r_q.st),
        .ext_prog   (ext_prog),
        .run_ale    (run_ale),
        .run_psen   (run_psen),
        .run_p0_out (run_p0_out),
        .run_p0_oe  (run_p0_oe),
        .run_p2_out (run_p2_out),
        .p0_sfr     (p0_sfr),
        .p1_sfr     (p1_sfr),
        .p2_sfr     (p2_sfr),
        .p3_sfr     (p3_sfr),
        .addr_hi    (addr_hi),
        .ale        (ale),
        .psen       (psen),
        .p0_out     (p0_out),
        .p0_oe      (p0_oe),
        .p1_out     (p1_out),
        .p2_out     (p2_out),
        .p3_out     (p3_out)
    );

    always_comb begin
        r_d          = r_q;
        r_d.int_prev = int_n;
        r_d.irq_take = 1'b0;
        r_d.restart  = 1'b0;
        if (rst_pin) begin
            r_d.st      = ST_RUN;
            r_d.pcon    = 2'b00;
            r_d.irq_src = SRC_INT0;
            r_d.restart = 1'b1;
        end else begin
            unique case (r_q.st)
                ST_RUN: begin
                    if (pcon_we) begin
                        if (pcon_wdata[PCON_PD_BIT]) begin
                            r_d.st   = ST_PDOWN;
                            r_d.pcon = 2'b10;
                        end else if (pcon_wdata[PCON_IDLE_BIT]) begin
                            r_d.st   = ST_IDLE;
                            r_d.pcon = 2'b01;
                        end
                    end
                end
                ST_IDLE: begin
                    if (idle_wake) begin
                        r_d.st       = ST_RUN;
                        r_d.pcon     = 2'b00;
                        r_d.irq_take = 1'b1;
                        r_d.irq_src  = idle_src;
                    end
                end
                ST_PDOWN: begin
                    if (pd_wake) begin
                        r_d.st      = ST_WARM;
                        r_d.pcon    = 2'b00;
                        r_d.irq_src = pd_src;
                    end
                end
                ST_WARM: begin
                    if (warm_last) begin
                        r_d.st       = ST_RUN;
                        r_d.irq_take = 1'b1;
                    end
                end
                default: r_d.st = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign pcon_bits  = r_q.pcon;
    assign cpu_clk_en = (r_q.st == ST_RUN);
    assign osc_en     = (r_q.st != ST_PDOWN);
    assign irq_take   = r_q.irq_take;
    assign irq_src    = r_q.irq_src;
    assign restart    = r_q.restart;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
    input logic       clk,
    input logic       rst_pin,
    input logic       ext_prog,
    input logic [1:0] int_edge,
    input logic       glob_en,
    input logic [1:0] pcon_bits,
    input logic       cpu_clk_en,
    input logic       osc_en,
    input logic       ale,
    input logic       psen,
    input logic       p0_oe,
    input logic       irq_take
);

    p_pd_gates_r2: assert property (@(posedge clk) disable iff (rst_pin)
        pcon_bits[1] |-> (!osc_en && !cpu_clk_en));

    p_idle_gates_r2: assert property (@(posedge clk) disable iff (rst_pin)
        pcon_bits[0] |-> (osc_en && !cpu_clk_en));

    p_pd_strobes_r3: assert property (@(posedge clk) disable iff (rst_pin)
        !osc_en |-> (!ale && !psen));

    p_idle_strobes_r3: assert property (@(posedge clk) disable iff (rst_pin)
        pcon_bits[0] |-> (ale && psen));

    p_p0_float_r4: assert property (@(posedge clk) disable iff (rst_pin)
        (!cpu_clk_en && ext_prog) |-> !p0_oe);

    p_edge_hold_r5: assert property (@(posedge clk) disable iff (rst_pin)
        (pcon_bits[1] && int_edge == 2'b11) |=> pcon_bits[1]);

    p_ea_hold_r5: assert property (@(posedge clk) disable iff (rst_pin)
        (pcon_bits[1] && !glob_en) |=> pcon_bits[1]);

    p_irq_pulse_r6: assert property (@(posedge clk) disable iff (rst_pin)
        irq_take |=> !irq_take);

    p_wake_run_r7: assert property (@(posedge clk) disable iff (rst_pin)
        irq_take |-> (cpu_clk_en && osc_en && pcon_bits == 2'b00));

    p_reset_r9: assert property (@(posedge clk) disable iff (rst_pin)
        $fell(rst_pin) |-> (cpu_clk_en && osc_en && pcon_bits == 2'b00));

endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
    .clk        (clk),
    .rst_pin    (rst_pin),
    .ext_prog   (ext_prog),
    .int_edge   (int_edge),
    .glob_en    (glob_en),
    .pcon_bits  (pcon_bits),
    .cpu_clk_en (cpu_clk_en),
    .osc_en     (osc_en),
    .ale        (ale),
    .psen       (psen),
    .p0_oe      (p0_oe),
    .irq_take   (irq_take)
);

// File: tb/lpm_ctrl_test.sv
module lpm_ctrl_test;

    localparam int W = 4;

    logic       clk = 1'b0;
    logic       rst_pin = 1'b1;
    logic       pcon_we = 1'b0;
    logic [7:0] pcon_wdata = 8'h00;
    logic       ext_prog = 1'b0;
    logic [1:0] int_n = 2'b11;
    logic [1:0] int_en = 2'b00;
    logic [1:0] int_edge = 2'b00;
    logic       glob_en = 1'b0;
    logic       periph_irq = 1'b0;
    logic       run_ale = 1'b0;
    logic       run_psen = 1'b1;
    logic [7:0] run_p0_out = 8'h3C;
    logic       run_p0_oe = 1'b1;
    logic [7:0] run_p2_out = 8'hC3;
    logic [7:0] p0_sfr = 8'hA5, p1_sfr = 8'h5A, p2_sfr = 8'h96, p3_sfr = 8'h69;
    logic [7:0] addr_hi = 8'hE1;

    logic [1:0] pcon_bits, irq_src;
    logic       cpu_clk_en, osc_en, ale, psen, p0_oe, irq_take, restart;
    logic [7:0] p0_out, p1_out, p2_out, p3_out;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    lpm_ctrl #(.PORT_W(8), .WARM_CYCLES(W)) uut (
        .clk(clk), .rst_pin(rst_pin), .pcon_we(pcon_we), .pcon_wdata(pcon_wdata),
        .ext_prog(ext_prog), .int_n(int_n), .int_en(int_en), .int_edge(int_edge),
        .glob_en(glob_en), .periph_irq(periph_irq), .run_ale(run_ale),
        .run_psen(run_psen), .run_p0_out(run_p0_out), .run_p0_oe(run_p0_oe),
        .run_p2_out(run_p2_out), .p0_sfr(p0_sfr), .p1_sfr(p1_sfr), .p2_sfr(p2_sfr),
        .p3_sfr(p3_sfr), .addr_hi(addr_hi), .pcon_bits(pcon_bits),
        .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .ale(ale), .psen(psen),
        .p0_out(p0_out), .p0_oe(p0_oe), .p1_out(p1_out), .p2_out(p2_out),
        .p3_out(p3_out), .irq_take(irq_take), .irq_src(irq_src), .restart(restart)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            report();
        end
    end

    task automatic do_reset();
        rst_pin = 1'b1;
        pcon_we = 1'b0;
        int_n = 2'b11;
        periph_irq = 1'b0;
        repeat (2) @(negedge clk);
        rst_pin = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_pcon(input logic [7:0] v);
        pcon_we = 1'b1;
        pcon_wdata = v;
        @(negedge clk);
        pcon_we = 1'b0;
    endtask

    initial begin
        // R9 reset state
        rst_pin = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 restart in reset", restart, 1);
        chk("R9 gates in reset", {cpu_clk_en, osc_en}, 2'b11);
        chk("R9 pcon in reset", pcon_bits, 0);
        rst_pin = 1'b0;
        @(negedge clk);
        chk("R9 restart after release", restart, 0);

        // R3 R4 run passthrough
        chk("R3 run strobes", {ale, psen}, {run_ale, run_psen});
        chk("R4 run bus", {p0_out, p0_oe, p2_out}, {run_p0_out, run_p0_oe, run_p2_out});

        // R1 R2 R3 R4 mode x memory sweep
        for (int ext = 0; ext < 2; ext++) begin
            for (int md = 0; md < 2; md++) begin
                logic idle_m;
                idle_m = (md == 0);
                do_reset();
                ext_prog = ext[0];
                p0_sfr = 8'h11 + 8'(ext * 16 + md);
                p2_sfr = 8'h80 + 8'(ext * 4 + md);
                write_pcon(idle_m ? 8'h01 : 8'h02);
                chk("R1 pcon after write", pcon_bits, idle_m ? 2'b01 : 2'b10);
                chk("R2 cpu clock gate", cpu_clk_en, 0);
                chk("R2 oscillator gate", osc_en, idle_m);
                chk("R3 ALE", ale, idle_m);
                chk("R3 PSEN", psen, idle_m);
                chk("R4 p0 oe", p0_oe, !ext[0]);
                if (ext == 0) chk("R4 p0 data", p0_out, p0_sfr);
                chk("R4 p1", p1_out, p1_sfr);
                chk("R4 p2", p2_out, (idle_m && ext == 1) ? addr_hi : p2_sfr);
                chk("R4 p3", p3_out, p3_sfr);
            end
        end
        ext_prog = 1'b0;

        // R5 R6 R8 power-down wake sweep
        for (int k = 0; k < 2; k++) begin
            for (int c = 0; c < 8; c++) begin
                logic exp_w;
                exp_w = c[0] && c[1] && !c[2];
                do_reset();
                int_en = 2'(c[0]) << k;
                glob_en = c[1];
                int_edge = 2'(c[2]) << k;
                write_pcon(8'h02);
                int_n[k] = 1'b0;
                periph_irq = 1'b1;
                @(negedge clk);
                if (exp_w) begin
                    chk("R6 osc on after wake", osc_en, 1);
                    chk("R6 pcon cleared", pcon_bits, 0);
                    chk("R6 cpu held", cpu_clk_en, 0);
                    chk("R3 warm strobes low", {ale, psen}, 2'b00);
                    repeat (W - 1) @(negedge clk);
                    chk("R6 cpu held to end of warm-up", cpu_clk_en, 0);
                    @(negedge clk);
                    chk("R6 cpu released", cpu_clk_en, 1);
                    chk("R6 irq pulse", irq_take, 1);
                    chk("R8 pd source", irq_src, k);
                    @(negedge clk);
                    chk("R6 irq single cycle", irq_take, 0);
                end else begin
                    repeat (W + 2) @(negedge clk);
                    chk("R5 stays in power-down", {osc_en, pcon_bits}, 3'b010);
                    chk("R5 no irq", irq_take, 0);
                end
                int_n = 2'b11;
                periph_irq = 1'b0;
            end
        end

        // R7 R8 idle wake sweep
        for (int k = 0; k < 2; k++) begin
            for (int c = 0; c < 8; c++) begin
                logic exp_w;
                exp_w = c[0] && c[1];
                do_reset();
                int_en = 2'(c[0]) << k;
                glob_en = c[1];
                int_edge = 2'(c[2]) << k;
                write_pcon(8'h01);
                int_n[k] = 1'b0;
                @(negedge clk);
                chk("R7 idle wake", cpu_clk_en, exp_w);
                chk("R7 idle pcon", pcon_bits, exp_w ? 2'b00 : 2'b01);
                chk("R7 idle irq", irq_take, exp_w);
                if (exp_w) chk("R8 idle source", irq_src, k);
                int_n = 2'b11;
            end
        end

        // R7 edge mode: pin already low before idle
        do_reset();
        int_en = 2'b01; glob_en = 1'b1; int_edge = 2'b01;
        int_n[0] = 1'b0;
        @(negedge clk);
        write_pcon(8'h01);
        repeat (3) @(negedge clk);
        chk("R7 held-low edge pin no wake", pcon_bits, 2'b01);
        int_n[0] = 1'b1;
        @(negedge clk);
        int_n[0] = 1'b0;
        @(negedge clk);
        chk("R7 fresh falling edge wakes", {cpu_clk_en, irq_take}, 2'b11);

        // R8 priority
        for (int p = 0; p < 3; p++) begin
            do_reset();
            int_en = 2'b11; glob_en = 1'b1; int_edge = 2'b00;
            write_pcon(8'h01);
            int_n = (p == 0) ? 2'b00 : (p == 1) ? 2'b01 : 2'b11;
            periph_irq = 1'b1;
            @(negedge clk);
            chk("R8 priority source", irq_src, p);
            chk("R8 priority wake", irq_take, 1);
        end
        // R7 periph with global enable off
        do_reset();
        glob_en = 1'b0;
        write_pcon(8'h01);
        periph_irq = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 periph gated by global enable", pcon_bits, 2'b01);

        // R9 reset from power-down and idle
        for (int md = 0; md < 2; md++) begin
            do_reset();
            write_pcon(md == 0 ? 8'h02 : 8'h01);
            rst_pin = 1'b1;
            @(negedge clk);
            chk("R9 reset exits mode", {cpu_clk_en, osc_en, pcon_bits}, 4'b1100);
            chk("R9 restart flag", restart, 1);
            rst_pin = 1'b0;
            @(negedge clk);
            chk("R9 restart drops", restart, 0);
        end

        // R10 write during reset ignored
        rst_pin = 1'b1;
        pcon_we = 1'b1; pcon_wdata = 8'h02;
        @(negedge clk);
        pcon_we = 1'b0;
        rst_pin = 1'b0;
        @(negedge clk);
        chk("R10 write in reset ignored", {osc_en, pcon_bits}, 3'b100);

        // R10 write while idle ignored
        do_reset();
        glob_en = 1'b0;
        write_pcon(8'h01);
        write_pcon(8'h02);
        chk("R10 write in idle ignored", {osc_en, pcon_bits}, 3'b101);

        // R1 both bits, upper bits only
        do_reset();
        write_pcon(8'h03);
        chk("R1 power-down wins", pcon_bits, 2'b10);
        do_reset();
        write_pcon(8'hFC);
        chk("R1 upper bits ignored", {cpu_clk_en, pcon_bits}, 3'b100);

        report();
    end

endmodule